// File: doc/BRIEF.md
# Asynchronous EPROM Read Sequencer

This block sits on the host side of a bank of asynchronous byte-wide read-only memories that share one address bus, one data bus and one output-enable line, with a separate chip-enable line for each device. A client hands it a byte address, and the top address bits pick the device, through a valid/ready handshake. The block then drives the address and the selected chip enable. It pulls output enable low at the latest point that still meets both access delays, and it latches the data bus once those delays have run out. The byte comes back on a one-cycle response strobe.

Every delay is given in picoseconds together with the clock period and is rounded up to whole cycles. Address-to-data and chip-enable-to-data are taken as one delay. The capture point is the larger of that delay and the output-enable-to-data delay. After output enable rises, the block holds off any other device for the bus float time. A back-to-back read of the same device keeps its chip enable low and may start on the very next cycle. When no request follows, the chip enable is released once the float time is over, so that the device drops into standby.

Top module: `eprom_read_ctrl`

## Requirements
- R1: Reset, and any cycle in which reset is held low, leave every chip-enable output high (1), output enable high, the response strobe low and the request ready output high.
- R2: A request is taken only in a cycle with both valid and ready high. While a read is in progress (from acceptance until the response), ready is low. A request with valid low changes no memory-side output.
- R3: Output enable falls LEAD = SAMPLE - OE_CYC cycles after the edge that launches the address, where OE_CYC = ceil(T_OE_PS / CLK_PERIOD_PS). With the defaults this is 10 cycles.
- R4: The data bus is captured SAMPLE = max(ACC_CYC, OE_CYC) cycles after the launch edge, where ACC_CYC = ceil(T_ACC_PS / CLK_PERIOD_PS). With the defaults this is 18 cycles. At that edge the response strobe goes high for exactly one cycle with the captured byte, and output enable rises.
- R5: Address and chip-enable outputs do not change while output enable is low.
- R6: A request to the device that has just been read is accepted on the cycle after the response. Its chip enable stays low across the two reads and never rises.
- R7: A request to a different device is not accepted until DF_CYC = ceil(T_DF_PS / CLK_PERIOD_PS) cycles after output enable rose (5 with the defaults). No chip enable falls earlier than that.
- R8: With no request pending, the selected chip enable returns high exactly DF_CYC cycles after output enable rose.
- R9: The request address is {device index, byte address}. The device index is bit 15 with the defaults and selects chip enable 0 or 1 (low active). The low 15 bits drive the memory address. At most one chip enable is low at any time.
- R10: Parameters are checked when the design is built: positive widths and delays, and a device count that is a power of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request valid |
| req_ready_o | output | 1 | Controller can take a request this cycle |
| req_addr_i | input | ADDR_W+log2(NUM_CHIPS) | Device index (high bits) and byte address |
| rsp_valid_o | output | 1 | One-cycle strobe: read data valid |
| rsp_data_o | output | DATA_W | Byte read from memory |
| mem_addr_o | output | ADDR_W | Address to the memories |
| mem_ce_no | output | NUM_CHIPS | Chip enables, one per device, active low |
| mem_oe_no | output | 1 | Shared output enable, active low |
| mem_data_i | input | DATA_W | Data bus from the memories |

## Verification
The bench models the memory so that it drives a wrong value until the address, chip enable and output enable have each been stable long enough. A controller that captures one cycle early, or lowers output enable one cycle too soon, therefore returns a wrong byte or shows the wrong edge cycle. The stimulus alternates same-device and cross-device back-to-back reads. A design that waits the float time for the same device, or skips it for a different one, shows the wrong acceptance delay and trips the bench's contention monitor. Directed cases cover the chip-enable release into standby, requests held without valid, and reset in the middle of an access, where a design that kept output enable low would be caught.

// File: rtl/eprd_pkg.sv
package eprd_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ACCESS = 2'd1,
      ST_FLOAT  = 2'd2
   } rd_state_e;

   // round a delay up to whole clock cycles
   function automatic int unsigned cyc_ceil(input int unsigned t_ps, input int unsigned clk_ps);
      return (t_ps + clk_ps - 1) / clk_ps;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/eprd_cycle_timer.sv
module eprd_cycle_timer #(
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             inc_i,
   output logic [CNT_W-1:0] cnt_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    cnt_o <= '0;
      else if (clr_i) cnt_o <= '0;
      else if (inc_i) cnt_o <= cnt_o + 1'b1;
   end

   // R4: the phase counter is sized so that it never wraps inside a phase
   a_r4_timer_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc_i && !clr_i) |-> (cnt_o != '1));

endmodule

// File: rtl/eprd_ce_decode.sv
module eprd_ce_decode #(
   parameter int unsigned NUM_CHIPS = 2,
   parameter int unsigned CHIP_W    = 1
) (
   input  logic [CHIP_W-1:0]    chip_i,
   input  logic                 active_i,
   output logic [NUM_CHIPS-1:0] ce_no
);

   for (genvar g = 0; g < NUM_CHIPS; g++) begin : g_ce
      assign ce_no[g] = ~(active_i && (chip_i == CHIP_W'(g)));
   end

endmodule

// File: rtl/eprd_read_seq.sv
module eprd_read_seq
   import eprd_pkg::*;
#(
   parameter int unsigned ADDR_W     = 15,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned CHIP_W     = 1,
   parameter int unsigned CNT_W      = 5,
   parameter int unsigned LEAD_CYC   = 10,
   parameter int unsigned SAMPLE_CYC = 18,
   parameter int unsigned DF_CYC     = 5
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              req_valid_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [CHIP_W-1:0] req_chip_i,
   output logic              req_ready_o,
   input  logic [CNT_W-1:0]  cnt_i,
   output logic              tmr_clr_o,
   output logic              tmr_inc_o,
   input  logic [DATA_W-1:0] mem_data_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [CHIP_W-1:0] chip_o,
   output logic              active_o,
   output logic              oe_no,
   output logic              rsp_valid_o,
   output logic [DATA_W-1:0] rsp_data_o
);

   rd_state_e state_q;
   logic      same_chip;
   logic      float_done;
   logic      sample_hit;
   logic      lead_hit;
   logic      oe_at_accept;
   logic      accept;

   assign same_chip  = (req_chip_i == chip_o);
   assign float_done = (state_q == ST_FLOAT) && (cnt_i == CNT_W'(DF_CYC - 1));
   assign sample_hit = (state_q == ST_ACCESS) && (cnt_i == CNT_W'(SAMPLE_CYC - 1));

   // output enable either goes low with the address or after a lead phase
   if (LEAD_CYC == 0) begin : g_oe_now
      assign oe_at_accept = 1'b1;
      assign lead_hit     = 1'b0;
   end else begin : g_oe_lead
      assign oe_at_accept = 1'b0;
      assign lead_hit     = (state_q == ST_ACCESS) && (cnt_i == CNT_W'(LEAD_CYC - 1));
   end

   assign req_ready_o = (state_q == ST_IDLE) ||
                        ((state_q == ST_FLOAT) && (same_chip || float_done));
   assign accept      = req_valid_i && req_ready_o;
   assign tmr_clr_o   = accept || sample_hit;
   assign tmr_inc_o   = (state_q != ST_IDLE);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q     <= ST_IDLE;
         addr_o      <= '0;
         chip_o      <= '0;
         active_o    <= 1'b0;
         oe_no       <= 1'b1;
         rsp_valid_o <= 1'b0;
         rsp_data_o  <= '0;
      end else begin
         rsp_valid_o <= 1'b0;
         if (accept) begin
            state_q  <= ST_ACCESS;
            addr_o   <= req_addr_i;
            chip_o   <= req_chip_i;
            active_o <= 1'b1;
            oe_no    <= !oe_at_accept;
         end else begin
            unique case (state_q)
               ST_ACCESS: begin
                  if (sample_hit) begin
                     oe_no       <= 1'b1;
                     rsp_valid_o <= 1'b1;
                     rsp_data_o  <= mem_data_i;
                     state_q     <= ST_FLOAT;
                  end else if (lead_hit) begin
                     oe_no <= 1'b0;
                  end
               end
               ST_FLOAT: begin
                  if (float_done) begin
                     state_q  <= ST_IDLE;
                     active_o <= 1'b0;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R2: no request is taken while output enable is low
   a_r2_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !oe_no |-> !req_ready_o);

   // R8: the device is released only out of the float phase
   a_r8_release_after_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(active_o) |-> $past(state_q == ST_FLOAT) && oe_no);

endmodule

// File: rtl/eprom_read_ctrl.sv
module eprom_read_ctrl
   import eprd_pkg::*;
#(
   parameter int unsigned ADDR_W        = 15,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned NUM_CHIPS     = 2,
   parameter int unsigned CLK_PERIOD_PS = 5000,
   parameter int unsigned T_ACC_PS      = 90000,
   parameter int unsigned T_OE_PS       = 40000,
   parameter int unsigned T_DF_PS       = 25000,
   localparam int unsigned SEL_W        = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 0,
   localparam int unsigned REQ_W        = ADDR_W + SEL_W
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 req_valid_i,
   output logic                 req_ready_o,
   input  logic [REQ_W-1:0]     req_addr_i,
   output logic                 rsp_valid_o,
   output logic [DATA_W-1:0]    rsp_data_o,
   output logic [ADDR_W-1:0]    mem_addr_o,
   output logic [NUM_CHIPS-1:0] mem_ce_no,
   output logic                 mem_oe_no,
   input  logic [DATA_W-1:0]    mem_data_i
);

   localparam int unsigned CHIP_W     = (SEL_W > 0) ? SEL_W : 1;
   localparam int unsigned ACC_CYC    = cyc_ceil(T_ACC_PS, CLK_PERIOD_PS);
   localparam int unsigned OE_CYC     = cyc_ceil(T_OE_PS, CLK_PERIOD_PS);
   localparam int unsigned DF_CYC     = cyc_ceil(T_DF_PS, CLK_PERIOD_PS);
   localparam int unsigned SAMPLE_CYC = max2(ACC_CYC, OE_CYC);
   localparam int unsigned LEAD_CYC   = SAMPLE_CYC - OE_CYC;
   localparam int unsigned CNT_W      = $clog2(max2(SAMPLE_CYC, DF_CYC) + 2);
   localparam int unsigned AGE_W      = $clog2(DF_CYC + 2);

   // R10: parameter sanity
   initial begin : p_param_chk
      a_r10_params: assert (ADDR_W > 0 && DATA_W > 0 && NUM_CHIPS > 0 &&
                            CLK_PERIOD_PS > 0 && T_ACC_PS > 0 && T_OE_PS > 0 && T_DF_PS > 0 &&
                            (NUM_CHIPS & (NUM_CHIPS - 1)) == 0)
         else $error("eprom_read_ctrl: illegal parameter set");
   end

   logic [ADDR_W-1:0] req_byte;
   logic [CHIP_W-1:0] req_chip;
   logic [CHIP_W-1:0] chip_q;
   logic              active_q;
   logic [CNT_W-1:0]  cnt;
   logic              tmr_clr;
   logic              tmr_inc;

   assign req_byte = req_addr_i[ADDR_W-1:0];
   if (SEL_W > 0) begin : g_multi
      assign req_chip = req_addr_i[REQ_W-1:ADDR_W];
   end else begin : g_single
      assign req_chip = '0;
   end

   eprd_cycle_timer #(.CNT_W(CNT_W)) timer_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (tmr_clr),
      .inc_i  (tmr_inc),
      .cnt_o  (cnt)
   );

   eprd_read_seq #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .CHIP_W     (CHIP_W),
      .CNT_W      (CNT_W),
      .LEAD_CYC   (LEAD_CYC),
      .SAMPLE_CYC (SAMPLE_CYC),
      .DF_CYC     (DF_CYC)
   ) seq_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .req_valid_i (req_valid_i),
      .req_addr_i  (req_byte),
      .req_chip_i  (req_chip),
      .req_ready_o (req_ready_o),
      .cnt_i       (cnt),
      .tmr_clr_o   (tmr_clr),
      .tmr_inc_o   (tmr_inc),
      .mem_data_i  (mem_data_i),
      .addr_o      (mem_addr_o),
      .chip_o      (chip_q),
      .active_o    (active_q),
      .oe_no       (mem_oe_no),
      .rsp_valid_o (rsp_valid_o),
      .rsp_data_o  (rsp_data_o)
   );

   eprd_ce_decode #(.NUM_CHIPS(NUM_CHIPS), .CHIP_W(CHIP_W)) dec_i (
      .chip_i   (chip_q),
      .active_i (active_q),
      .ce_no    (mem_ce_no)
   );

   // checker: cycles since output enable last rose, saturating
   logic             oe_prev_q;
   logic [AGE_W-1:0] float_age_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         oe_prev_q   <= 1'b1;
         float_age_q <= '1;
      end else begin
         oe_prev_q <= mem_oe_no;
         if (mem_oe_no && !oe_prev_q)  float_age_q <= AGE_W'(1);
         else if (float_age_q != '1)   float_age_q <= float_age_q + 1'b1;
      end
   end

   // R9: never two devices selected
   a_r9_one_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(~mem_ce_no));

   // R5: address and selects frozen while the device drives the bus
   a_r5_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!mem_oe_no && $past(!mem_oe_no)) |-> ($stable(mem_addr_o) && $stable(mem_ce_no)));

   // R4: response coincides with output enable rising
   a_r4_rsp_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_valid_o |-> (mem_oe_no && $past(!mem_oe_no)));

   // R4: response strobe lasts one cycle
   a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_valid_o |=> !rsp_valid_o);

   // R7: no chip enable falls inside the float window
   a_r7_float_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(~mem_ce_no & $past(mem_ce_no))) |-> (float_age_q >= AGE_W'(DF_CYC)));

endmodule

// File: tb/eprom_read_ctrl_tb_top.sv
module eprom_read_ctrl_tb_top;

   localparam int CLK_PS  = 5000;
   localparam int ACC     = (90000 + CLK_PS - 1) / CLK_PS;
   localparam int OEC     = (40000 + CLK_PS - 1) / CLK_PS;
   localparam int DF      = (25000 + CLK_PS - 1) / CLK_PS;
   localparam int SAMP    = (ACC > OEC) ? ACC : OEC;
   localparam int LEAD    = SAMP - OEC;

   // {expected handshake wait in cycles, request address}
   localparam logic [19:0] VEC [8] = '{
      {4'd1, 16'h0000}, {4'd1, 16'h0001}, {4'd1, 16'h7FFF}, {4'd5, 16'h8000},
      {4'd1, 16'hABCD}, {4'd5, 16'h1234}, {4'd5, 16'hFFFF}, {4'd1, 16'hFFFE}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [15:0] req_addr = '0;
   logic        rsp_valid;
   logic [7:0]  rsp_data;
   logic [14:0] mem_addr;
   logic [1:0]  mem_ce_n;
   logic        mem_oe_n;
   logic [7:0]  mem_data = 8'hEE;

   int total = 0;
   int fails = 0;
   int cyc   = 0;

   always #2500ps clk = ~clk;

   eprom_read_ctrl dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .req_valid_i (req_valid),
      .req_ready_o (req_ready),
      .req_addr_i  (req_addr),
      .rsp_valid_o (rsp_valid),
      .rsp_data_o  (rsp_data),
      .mem_addr_o  (mem_addr),
      .mem_ce_no   (mem_ce_n),
      .mem_oe_no   (mem_oe_n),
      .mem_data_i  (mem_data)
   );

   function automatic logic [7:0] exp_byte(input logic [15:0] a);
      return a[7:0] ^ {a[14:8], 1'b0} ^ (a[15] ? 8'h96 : 8'h21);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // memory model and bus monitors, evaluated mid-cycle
   logic [14:0] p_addr = '0;
   logic [1:0]  p_ce   = 2'b11;
   logic        p_oe   = 1'b1;
   int addr_age = 0, ce_age = 0, oe_age = 0, rise_age = 100;
   int last_sel = -1;
   int ce_rises = 0;
   int v_hold = 0, v_float = 0, v_multi = 0;

   always @(negedge clk) begin
      int sel;
      addr_age = (mem_addr != p_addr) ? 0 : ((addr_age < 100) ? addr_age + 1 : addr_age);
      ce_age   = (mem_ce_n != p_ce)   ? 0 : ((ce_age < 100) ? ce_age + 1 : ce_age);
      oe_age   = (!mem_oe_n && p_oe)  ? 0 : ((oe_age < 100) ? oe_age + 1 : oe_age);
      rise_age = (mem_oe_n && !p_oe)  ? 0 : ((rise_age < 100) ? rise_age + 1 : rise_age);
      sel = (mem_ce_n == 2'b10) ? 0 : (mem_ce_n == 2'b01) ? 1 : -1;
      if (rst_n) begin
         if (!mem_oe_n && !p_oe && (mem_addr != p_addr || mem_ce_n != p_ce)) v_hold++;
         if ($countones(~mem_ce_n) > 1) v_multi++;
         if (((~mem_ce_n & p_ce) != 2'b00) && sel >= 0 && sel != last_sel && last_sel >= 0 &&
             rise_age < DF) v_float++;
      end
      if ((mem_ce_n & ~p_ce) != 2'b00) ce_rises++;
      if (sel >= 0) last_sel = sel;
      if (!mem_oe_n && sel >= 0 && addr_age >= ACC - 1 && ce_age >= ACC - 1 && oe_age >= OEC - 1)
         mem_data = exp_byte({sel[0], mem_addr});
      else
         mem_data = 8'hEE;
      p_addr = mem_addr;
      p_ce   = mem_ce_n;
      p_oe   = mem_oe_n;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         fails++;
         total++;
         $display("FAIL watchdog (R4): cycles %0d expected below %0d", cyc, 20000);
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   // issue one read at a negedge; returns at the negedge that sees the response
   task automatic do_read(input logic [15:0] a, input int exp_wait, input bit same);
      int  n = 0;
      int  lat = 0;
      int  oe_lat = -1;
      int  rises0;
      bit  acc = 1'b0;
      rises0    = ce_rises;
      req_addr  = a;
      req_valid = 1'b1;
      while (!acc && n < 100) begin
         #1;
         n++;
         acc = req_ready;
         @(posedge clk);
         if (!acc) @(negedge clk);
      end
      @(negedge clk);
      req_valid = 1'b0;
      chk(n == exp_wait, same ? "R6" : "R7", "handshake wait", n, exp_wait);
      chk(mem_addr == a[14:0], "R9", "memory address", mem_addr, a[14:0]);
      chk(mem_ce_n == (a[15] ? 2'b01 : 2'b10), "R9", "chip enable", mem_ce_n,
          a[15] ? 2'b01 : 2'b10);
      chk(!req_ready, "R2", "ready while busy", req_ready, 0);
      if (same) chk(ce_rises == rises0, "R6", "chip enable rises", ce_rises - rises0, 0);
      while (!rsp_valid && lat < 100) begin
         @(negedge clk);
         lat++;
         if (!mem_oe_n && oe_lat < 0) oe_lat = lat;
      end
      chk(oe_lat == LEAD, "R3", "output enable fall cycle", oe_lat, LEAD);
      chk(lat == SAMP, "R4", "response latency", lat, SAMP);
      chk(rsp_data == exp_byte(a), "R4", "response data", rsp_data, exp_byte(a));
      chk(mem_oe_n, "R4", "output enable at response", mem_oe_n, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(mem_ce_n == 2'b11, "R1", "reset chip enables", mem_ce_n, 2'b11);
      chk(mem_oe_n == 1'b1, "R1", "reset output enable", mem_oe_n, 1);
      chk(!rsp_valid, "R1", "reset response", rsp_valid, 0);
      chk(req_ready, "R1", "reset ready", req_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < 8; i++) begin
         logic [15:0] a;
         bit same;
         a    = VEC[i][15:0];
         same = (i > 0) && (VEC[i - 1][15] == a[15]);
         do_read(a, int'(VEC[i][19:16]), same);
      end

      // R8: release into standby after the float time
      for (int j = 1; j <= DF; j++) begin
         @(negedge clk);
         if (j == DF - 1) chk(mem_ce_n == 2'b01, "R8", "chip enable before release", mem_ce_n, 2'b01);
         if (j == DF)     chk(mem_ce_n == 2'b11, "R8", "chip enable after release", mem_ce_n, 2'b11);
      end

      // R2: address changes with valid low do nothing
      for (int j = 0; j < 4; j++) begin
         req_addr = 16'h1111 * 16'(j + 3);
         @(negedge clk);
         chk(mem_ce_n == 2'b11 && mem_oe_n, "R2", "outputs with valid low",
             {mem_ce_n, mem_oe_n}, 3'b111);
      end

      // R1: reset in the middle of an access
      req_addr  = 16'h4321;
      req_valid = 1'b1;
      #1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      repeat (LEAD + 2) @(negedge clk);
      chk(!mem_oe_n, "R3", "output enable low mid access", mem_oe_n, 0);
      rst_n = 1'b0;
      @(negedge clk);
      chk(mem_ce_n == 2'b11, "R1", "chip enables in reset", mem_ce_n, 2'b11);
      chk(mem_oe_n, "R1", "output enable in reset", mem_oe_n, 1);
      chk(!rsp_valid && req_ready, "R1", "response and ready in reset",
          {rsp_valid, req_ready}, 2'b01);
      rst_n = 1'b1;
      @(negedge clk);
      do_read(16'h4321, 1, 1'b0);

      repeat (DF + 2) @(negedge clk);
      chk(v_hold == 0, "R5", "address or enable change under output enable", v_hold, 0);
      chk(v_float == 0, "R7", "cross-device select inside float", v_float, 0);
      chk(v_multi == 0, "R9", "multiple chip enables", v_multi, 0);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule